// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block drives an external successive-approximation converter core through one conversion at a time. Software programs a settling count and then writes a control word. That word selects one of up to eight analog inputs, switches the converter supply on and starts a conversion in a single access. The sequencer then waits the programmed number of clocks so the core can settle. After that it raises a request toward the core and holds it until the core signals completion. It then stores the returned sample and flags an interrupt.

Software reaches the block through a flat 32-bit register port with four word locations: sample, status, control and settling count. Reads are combinational on the address. Writes take effect at the clock edge. The completion flag stays set until the next accepted control write, and the interrupt pin follows that flag only while the enable bit is set. Writing a control word with the supply bit clear switches the converter off and starts nothing.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every register reads zero and `irq`, `cnv_req` and `cnv_pwr` are low.
- R2: Byte address 0x0 returns the sample, 0x4 the status, 0x8 the control word and 0xC the settling count. Only the low 6 bits of the settling count are stored, so writing 0xFFFFFFC5 reads back 0x05. The control word reads back the channel in bits [2:0], supply-on in bit 3, interrupt enable in bit 5 and the completion flag in bit 6. All other bits read zero.
- R3: A control write with bit 3 set, made while idle, starts a conversion. Status bit 0 (busy) reads one from that write until the sample has been stored, and zero again afterwards.
- R4: `cnv_req` rises exactly N+1 clock cycles after the clock edge that accepts the starting control write, where N is the stored settling count (0 to 63). It stays high until the core returns `cnv_done`.
- R5: `cnv_chan` equals control bits [2:0] of the accepted write and does not change while busy.
- R6: On `cnv_done` during a conversion, the RES_W-bit value on `cnv_data` is stored right-justified in the sample register. The bits above RES_W read zero.
- R7: Storing a sample sets control bit 6. `irq` is high exactly when bit 6 and the enable bit 5 are both set.
- R8: Any accepted control write clears control bit 6, and so drops `irq`.
- R9: A control write made while busy is ignored: channel, supply, enable and the running conversion are all unaffected.
- R10: A control write with bit 3 clear drops `cnv_pwr` and starts no conversion. Busy stays zero and `cnv_req` stays low.
- R11: The sample register keeps its value until the next conversion completes, and a `cnv_done` pulse outside a conversion changes neither the sample nor bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the converter clock used for the settling count |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte address; bits [3:2] pick the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Completion interrupt, gated by the enable bit |
| cnv_pwr | output | 1 | Supply enable toward the converter core |
| cnv_chan | output | 3 | Selected analog input |
| cnv_req | output | 1 | Start-of-conversion, held until completion |
| cnv_done | input | 1 | One-cycle completion strobe from the core |
| cnv_data | input | 10 | Conversion result from the core |

## Verification
The assertions take for granted that the core pulses `cnv_done` for a single cycle and only after it has seen `cnv_req`. They also assume reset is held for at least one clock edge before any checking starts. The behavioural core in the bench counts a fixed latency of request cycles and then strobes completion once, so every completion stays inside that contract. The one stray completion pulse is driven deliberately while idle, where the design must ignore it. The random part of the stimulus only starts a conversion after the status register reads idle, and it draws settling counts only from the 6-bit range.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PWRUP = 2'd1,
        ST_CONV  = 2'd2,
        ST_DONE  = 2'd3
    } sar_state_e;

    // Word index of each register (byte address bits [3:2])
    localparam logic [1:0] IDX_SAMPLE = 2'd0;
    localparam logic [1:0] IDX_STATUS = 2'd1;
    localparam logic [1:0] IDX_CTRL   = 2'd2;
    localparam logic [1:0] IDX_SETTLE = 2'd3;

    // Control and status bit positions, decoded by software
    localparam int CHAN_FIELD_W  = 3;
    localparam int CTL_PWR_BIT   = 3;
    localparam int CTL_IE_BIT    = 5;
    localparam int CTL_FLAG_BIT  = 6;
    localparam int STAT_BUSY_BIT = 0;

    typedef struct packed {
        logic                    flag;
        logic                    ie;
        logic                    pwr;
        logic [CHAN_FIELD_W-1:0] chan;
    } ctrl_reg_t;

    function automatic logic [1:0] word_index(input logic [3:0] byte_addr);
        return byte_addr[3:2];
    endfunction

    function automatic logic [31:0] ctrl_view(input ctrl_reg_t c);
        logic [31:0] v;
        v = '0;
        v[CHAN_FIELD_W-1:0] = c.chan;
        v[CTL_PWR_BIT]      = c.pwr;
        v[CTL_IE_BIT]       = c.ie;
        v[CTL_FLAG_BIT]     = c.flag;
        return v;
    endfunction

endpackage

// File: rtl/sar_reg_bank.sv
module sar_reg_bank
    import sar_pkg::*;
#(
    parameter int DLY_W = 6,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             busy,
    input  logic             cap_en,
    input  logic [RES_W-1:0] cap_data,
    output logic [31:0]      rdata,
    output ctrl_reg_t        ctrl_q,
    output logic [DLY_W-1:0] settle_q,
    output logic [RES_W-1:0] sample_q,
    output logic             start
);

    logic ctrl_hit;
    logic settle_hit;
    logic accept;
    logic unused_wbits;

    assign ctrl_hit   = wr_en && (word_index(addr) == IDX_CTRL);
    assign settle_hit = wr_en && (word_index(addr) == IDX_SETTLE);
    assign accept     = ctrl_hit && !busy;
    assign start      = accept && wdata[CTL_PWR_BIT];

    assign unused_wbits = ^{wdata[31:7], wdata[4], addr[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            settle_q <= '0;
            sample_q <= '0;
        end else begin
            if (settle_hit) begin
                settle_q <= wdata[DLY_W-1:0];
            end
            if (accept) begin
                ctrl_q.chan <= wdata[CHAN_FIELD_W-1:0];
                ctrl_q.pwr  <= wdata[CTL_PWR_BIT];
                ctrl_q.ie   <= wdata[CTL_IE_BIT];
                ctrl_q.flag <= 1'b0;
            end else if (cap_en) begin
                ctrl_q.flag <= 1'b1;
            end
            if (cap_en) begin
                sample_q <= cap_data;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (word_index(addr))
            IDX_SAMPLE: rdata[RES_W-1:0]   = sample_q;
            IDX_STATUS: rdata[STAT_BUSY_BIT] = busy;
            IDX_CTRL:   rdata              = ctrl_view(ctrl_q);
            IDX_SETTLE: rdata[DLY_W-1:0]   = settle_q;
            default:    rdata              = '0;
        endcase
    end

endmodule

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sar_conv_fsm.sv
module sar_conv_fsm
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       settled,
    input  logic       cnv_done,
    output sar_state_e state_q,
    output logic       busy,
    output logic       req,
    output logic       capture,
    output logic       timer_run
);

    sar_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_PWRUP;
            ST_PWRUP: if (settled)  state_d = ST_CONV;
            ST_CONV:  if (cnv_done) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign req       = (state_q == ST_CONV);
    assign capture   = (state_q == ST_CONV) && cnv_done;
    assign timer_run = (state_q == ST_PWRUP);

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int DLY_W = 6,
    parameter int RES_W = 10
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 reg_wr,
    input  logic [3:0]                           reg_addr,
    input  logic [31:0]                          reg_wdata,
    output logic [31:0]                          reg_rdata,
    output logic                                 irq,
    output logic                                 cnv_pwr,
    output logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] cnv_chan,
    output logic                                 cnv_req,
    input  logic                                 cnv_done,
    input  logic [RES_W-1:0]                     cnv_data
);

    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    ctrl_reg_t        ctrl_q;
    logic [DLY_W-1:0] settle_q;
    logic [RES_W-1:0] sample_q;
    logic             start;
    logic             busy_w;
    logic             capture;
    logic             timer_run;
    logic             settled;
    sar_state_e       state_w;

    sar_reg_bank #(
        .DLY_W (DLY_W),
        .RES_W (RES_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (busy_w),
        .cap_en   (capture),
        .cap_data (cnv_data),
        .rdata    (reg_rdata),
        .ctrl_q   (ctrl_q),
        .settle_q (settle_q),
        .sample_q (sample_q),
        .start    (start)
    );

    sar_settle_timer #(
        .DLY_W (DLY_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (settle_q),
        .run      (timer_run),
        .expired  (settled)
    );

    sar_conv_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .settled   (settled),
        .cnv_done  (cnv_done),
        .state_q   (state_w),
        .busy      (busy_w),
        .req       (cnv_req),
        .capture   (capture),
        .timer_run (timer_run)
    );

    generate
        if (CH_W < CHAN_FIELD_W) begin : g_narrow_chan
            logic unused_chan_hi;
            assign unused_chan_hi = ^ctrl_q.chan[CHAN_FIELD_W-1:CH_W];
            assign cnv_chan = ctrl_q.chan[CH_W-1:0];
        end else begin : g_full_chan
            assign cnv_chan = ctrl_q.chan;
        end
    endgenerate

    assign cnv_pwr = ctrl_q.pwr;
    assign irq     = ctrl_q.flag & ctrl_q.ie;

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk
    import sar_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             cnv_req,
    input logic             cnv_pwr,
    input logic             cnv_done,
    input logic             busy,
    input sar_state_e       state,
    input logic             flag,
    input logic [CH_W-1:0]  chan,
    input logic [RES_W-1:0] sample
);

    // R10: a request is never raised toward an unpowered core
    p_req_powered_r10: assert property (@(posedge clk) disable iff (rst)
        cnv_req |-> cnv_pwr);

    // R3: status reports busy whenever a request is outstanding
    p_req_busy_r3: assert property (@(posedge clk) disable iff (rst)
        cnv_req |-> busy);

    // R4: a request only ever begins after the settling phase
    p_req_after_settle_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_req) |-> ($past(state) == ST_PWRUP));

    // R5: the channel holds steady across a conversion
    p_chan_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(chan));

    // R7: completion during a conversion raises the flag next cycle
    p_flag_on_done_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && cnv_done) |=> flag);

    // R11: the sample changes only after a completion inside a conversion
    p_sample_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(state == ST_CONV && cnv_done) |-> $stable(sample));

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(
    .CH_W  (CH_W),
    .RES_W (RES_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnv_req  (cnv_req),
    .cnv_pwr  (cnv_pwr),
    .cnv_done (cnv_done),
    .busy     (busy_w),
    .state    (state_w),
    .flag     (ctrl_q.flag),
    .chan     (cnv_chan),
    .sample   (sample_q)
);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH       = 8;
    localparam int DLY_W      = 6;
    localparam int RES_W      = 10;
    localparam int CORE_LAT   = 5;

    localparam logic [3:0] A_SAMPLE = 4'h0;
    localparam logic [3:0] A_STATUS = 4'h4;
    localparam logic [3:0] A_CTRL   = 4'h8;
    localparam logic [3:0] A_SETTLE = 4'hC;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             irq;
    logic             cnv_pwr;
    logic [2:0]       cnv_chan;
    logic             cnv_req;
    logic             cnv_done;
    logic [RES_W-1:0] cnv_data;

    logic             core_done  = 1'b0;
    logic             stray_done = 1'b0;
    logic [RES_W-1:0] core_val   = '0;
    int               core_cnt   = 0;

    int n_vec = 0;
    int n_bad = 0;

    assign cnv_done = core_done | stray_done;
    assign cnv_data = core_val;

    sar_seq_ctrl #(
        .N_CH  (N_CH),
        .DLY_W (DLY_W),
        .RES_W (RES_W)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .cnv_pwr   (cnv_pwr),
        .cnv_chan  (cnv_chan),
        .cnv_req   (cnv_req),
        .cnv_done  (cnv_done),
        .cnv_data  (cnv_data)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural converter core: strobes completion after CORE_LAT request cycles
    initial forever begin
        @(negedge clk);
        if (core_done) begin
            core_done = 1'b0;
        end else if (cnv_req) begin
            core_cnt++;
            if (core_cnt == CORE_LAT) begin
                core_done = 1'b1;
                core_cnt  = 0;
            end
        end
    end

    function automatic logic [31:0] exp_sample(input logic [RES_W-1:0] v);
        logic [31:0] r;
        r = '0;
        r[RES_W-1:0] = v;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        int k;
        k = 0;
        rd(A_STATUS, r);
        while (r[0] && k < 500) begin
            @(negedge clk);
            rd(A_STATUS, r);
            k++;
        end
    endtask

    task automatic run_conv(input int ch, input int dly, input bit ie,
                            input logic [RES_W-1:0] val, input string tag);
        logic [31:0] r;
        int k;
        core_val = val;
        wr(A_SETTLE, 32'(dly));
        wr(A_CTRL, (32'(ie) << 5) | 32'h8 | 32'(ch));
        k = 0;
        while (!cnv_req && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk({"R4 request delay ", tag}, 32'(k), 32'(dly + 1));
        chk({"R5 channel ", tag}, 32'(cnv_chan), 32'(ch));
        rd(A_STATUS, r);
        chk({"R3 busy ", tag}, r, 32'h1);
        wait_idle();
        rd(A_STATUS, r);
        chk({"R3 idle ", tag}, r, 32'h0);
        rd(A_SAMPLE, r);
        chk({"R6 sample ", tag}, r, exp_sample(val));
        rd(A_CTRL, r);
        chk({"R7 flag ", tag}, 32'(r[6]), 32'h1);
        chk({"R7 irq ", tag}, 32'(irq), 32'(ie));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [RES_W-1:0] held;
        void'($urandom(32'h5A17_C3E1));

        repeat (3) @(negedge clk);
        // R1: reset state, checked while reset is still held and after release
        rd(A_CTRL, r);
        chk("R1 ctrl in reset", r, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(A_SAMPLE, r); chk("R1 sample", r, 32'h0);
        rd(A_STATUS, r); chk("R1 status", r, 32'h0);
        rd(A_CTRL,   r); chk("R1 ctrl",   r, 32'h0);
        rd(A_SETTLE, r); chk("R1 settle", r, 32'h0);
        chk("R1 pins", {29'b0, irq, cnv_req, cnv_pwr}, 32'h0);

        // R2: settle count keeps 6 bits; control readback fields
        wr(A_SETTLE, 32'hFFFF_FFC5);
        rd(A_SETTLE, r); chk("R2 settle width", r, 32'h05);
        wr(A_CTRL, 32'hFFFF_FF26 & 32'h0000_0026);
        rd(A_CTRL, r); chk("R2 ctrl readback", r, 32'h26);

        // R10: supply bit clear starts nothing
        repeat (4) @(negedge clk);
        rd(A_STATUS, r); chk("R10 no busy", r, 32'h0);
        chk("R10 no request", 32'(cnv_req), 32'h0);
        chk("R10 supply off", 32'(cnv_pwr), 32'h0);

        // Directed corners: settle limits, channel limits, full-scale sample
        run_conv(0, 0,  1'b1, 10'h3FF, "dly0 ch0");
        run_conv(7, 63, 1'b1, 10'h000, "dly63 ch7");
        run_conv(3, 1,  1'b0, 10'h2A5, "ie off");

        // R8, R10, R11: clearing write drops flag and supply, sample holds
        run_conv(5, 4, 1'b1, 10'h155, "before clear");
        wr(A_CTRL, 32'h20);
        rd(A_CTRL, r); chk("R8 flag cleared", r, 32'h20);
        chk("R8 irq dropped", 32'(irq), 32'h0);
        chk("R10 supply off after clear", 32'(cnv_pwr), 32'h0);
        rd(A_SAMPLE, r); chk("R11 sample held", r, 32'h155);

        // R11: stray completion while idle is ignored
        core_val = 10'h0F0;
        @(negedge clk); stray_done = 1'b1;
        @(negedge clk); stray_done = 1'b0;
        @(negedge clk);
        rd(A_SAMPLE, r); chk("R11 stray done sample", r, 32'h155);
        rd(A_CTRL, r);   chk("R11 stray done flag", r, 32'h20);

        // R9: control write during a conversion is ignored
        core_val = 10'h1C3;
        wr(A_SETTLE, 32'd20);
        wr(A_CTRL, 32'h0A);
        wr(A_CTRL, 32'h2D);
        chk("R9 channel kept", 32'(cnv_chan), 32'h2);
        wait_idle();
        rd(A_CTRL, r);   chk("R9 ctrl kept", r, 32'h4A);
        rd(A_SAMPLE, r); chk("R9 sample", r, 32'h1C3);
        chk("R9 irq stays gated", 32'(irq), 32'h0);

        // Random conversions
        for (int i = 0; i < 40; i++) begin
            int ch;
            int dly;
            bit ie;
            ch   = int'($urandom_range(N_CH - 1, 0));
            dly  = int'($urandom_range(63, 0));
            ie   = 1'($urandom_range(1, 0));
            held = RES_W'($urandom);
            run_conv(ch, dly, ie, held, "random");
        end

        finish_run();
    end

endmodule